// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counting timer. A clock prescaler of 1, 4 or 16 divides the clock into counting ticks. On each tick the counter is compared with a programmable period value. When the two are equal, the counter returns to zero and a one-cycle match pulse goes out to neighbouring logic. A postscaler counts these matches. After a selectable number of matches, from 1 to 16, it sets a sticky interrupt flag. An interrupt-enable bit gates that flag onto the request line.

Software reaches the block through a small register port: a 2-bit address, a write strobe, 8-bit write data and combinational 8-bit read data. The address map is:

| Address | Register | Contents |
|---|---|---|
| 0 | counter | the count value |
| 1 | period | the period value |
| 2 | control | bits 6:3 postscale select, bit 2 run enable, bits 1:0 prescale select |
| 3 | interrupt | bit 1 interrupt enable, bit 0 sticky flag |

The run enable is held as a two-state machine. The state `ST_STOPPED` moves to `ST_RUNNING` on a control write with bit 2 set. The state `ST_RUNNING` returns to `ST_STOPPED` on a control write with bit 2 clear. Any other cycle leaves the state where it is.

Top module: `period_timer`

## Requirements
- R1: After reset, address 0 (counter) reads 0x00, address 1 (period) reads 0xFF, address 2 (control) reads 0x00 and address 3 (interrupt) reads 0x00.
- R2: Control bit 2 set to 1 makes the timer run. While control bit 2 is 0, the counter keeps its value unless software writes it.
- R3: Control bits 1:0 select the prescale. Code 00 gives a tick on every running cycle, code 01 on every 4th running cycle, and codes 10 and 11 on every 16th running cycle.
- R4: A write to address 0, 1 or 2 stores the write data and the register reads it back at the same address. Control bit 7 always reads 0. Reading a register changes nothing.
- R5: On a tick where the counter equals the period, the counter becomes 0 and `match_pulse` is 1 for that cycle. On any other tick the counter increments modulo 256 and `match_pulse` stays 0.
- R6: Control bits 6:3 hold a code N. The interrupt flag (address 3, bit 0) is set by the (N+1)th match pulse counted by the postscaler, after which the postscaler starts again from zero.
- R7: A write to address 0 or address 2 restarts both the prescaler and the postscaler from zero. No tick occurs in the cycle of that write.
- R8: Once set, the flag stays set until a write to address 3 with bit 0 equal to 0. Writing bit 0 equal to 1 leaves the flag unchanged. If a set event and a clearing write fall in the same cycle, the flag ends up set. Address 3, bit 1 stores the interrupt enable.
- R9: `irq` is 1 exactly when both the flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| match_pulse | output | 1 | One-cycle pulse when the counter wraps at the period |
| irq | output | 1 | Interrupt request: flag gated by enable |

## Verification
The bench goes after the following corner cases.

- **Equal codes 10 and 11.** A prescale decoder that treated them differently would show the wrong tick spacing on one of them.
- **Largest postscale ratio.** A postscaler with an off-by-one ratio would raise the flag one match early or late.
- **Period of zero.** Here every tick is a match. The bench issues a clearing write on every cycle against a set event on every cycle; a design that let the clear win would drop `irq`.
- **Counter already above the period.** A design that compared with greater-or-equal would wrap early instead of counting through 255 to 0.
- **Writes in mid-count.** A write to the counter or control register must restart the prescale phase. A design that kept the old phase would tick at the wrong cycle.
- **Writing 1 to the flag.** A design that let this write set the flag would read back a set flag.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;

    localparam logic [1:0] ADDR_COUNT  = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_INT    = 2'd3;

    localparam int CTRL_RUN_BIT = 2;
    localparam int POST_LSB     = 3;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int PW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PW-1:0] pre_cnt;
    logic [PW-1:0] last;

    always_comb begin
        unique case (sel)
            2'b00:   last = '0;
            2'b01:   last = PW'(3);
            default: last = PW'(15);
        endcase
    end

    assign tick = en && !clr && (pre_cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (clr)
            pre_cnt <= '0;
        else if (en)
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= last); // R3

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_cnt == '0)); // R7

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         match
);

    assign match = tick && (cnt == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (tick)
            cnt <= match ? '0 : cnt + 1'b1;
    end

    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (cnt == '0)); // R5

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !match && !ld) |=> (cnt == $past(cnt) + 1'b1)); // R5

endmodule

// File: rtl/timer_postscaler.sv
module timer_postscaler #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          match,
    input  logic [PW-1:0] sel,
    output logic          set_evt
);

    logic [PW-1:0] post_cnt;

    assign set_evt = match && (post_cnt == sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            post_cnt <= '0;
        else if (clr)
            post_cnt <= '0;
        else if (match)
            post_cnt <= set_evt ? '0 : post_cnt + 1'b1;
    end

    AST_POST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        post_cnt <= sel); // R6

    AST_POST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (post_cnt == '0)); // R7

endmodule

// File: rtl/period_timer.sv
module period_timer
    import timer_pkg::*;
#(
    parameter int DW = 8,
    parameter int PRE_W = 4,
    parameter int POST_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          match_pulse,
    output logic          irq
);

    localparam int PAD_W = DW - POST_W - 3;

    run_state_t        state, state_nxt;
    logic              run_en;
    logic [DW-1:0]     period_q;
    logic [POST_W-1:0] post_sel;
    logic [1:0]        pre_sel;
    logic              flag_q, ie_q;
    logic              wr_cnt, wr_per, wr_ctrl, wr_int, restart;
    logic              tick, match, set_evt;
    logic [DW-1:0]     cnt;

    assign wr_cnt  = reg_wr && (reg_addr == ADDR_COUNT);
    assign wr_per  = reg_wr && (reg_addr == ADDR_PERIOD);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_int  = reg_wr && (reg_addr == ADDR_INT);
    assign restart = wr_cnt || wr_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_STOPPED;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOPPED: if (wr_ctrl && reg_wdata[CTRL_RUN_BIT])  state_nxt = ST_RUNNING;
            ST_RUNNING: if (wr_ctrl && !reg_wdata[CTRL_RUN_BIT]) state_nxt = ST_STOPPED;
        endcase
    end

    always_comb begin
        run_en = (state == ST_RUNNING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '1;
            post_sel <= '0;
            pre_sel  <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_per)
                period_q <= reg_wdata;
            if (wr_ctrl) begin
                post_sel <= reg_wdata[POST_LSB +: POST_W];
                pre_sel  <= reg_wdata[1:0];
            end
            if (wr_int)
                ie_q <= reg_wdata[1];
            if (set_evt)
                flag_q <= 1'b1;
            else if (wr_int && !reg_wdata[0])
                flag_q <= 1'b0;
        end
    end

    timer_prescaler #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (run_en),
        .sel   (pre_sel),
        .tick  (tick)
    );

    timer_count_core #(.W(DW)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ld     (wr_cnt),
        .ld_val (reg_wdata),
        .period (period_q),
        .cnt    (cnt),
        .match  (match)
    );

    timer_postscaler #(.PW(POST_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .match   (match),
        .sel     (post_sel),
        .set_evt (set_evt)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_COUNT:  reg_rdata = cnt;
            ADDR_PERIOD: reg_rdata = period_q;
            ADDR_CTRL:   reg_rdata = {{PAD_W{1'b0}}, post_sel, run_en, pre_sel};
            default:     reg_rdata = {{(DW-2){1'b0}}, ie_q, flag_q};
        endcase
    end

    assign match_pulse = match;
    assign irq         = flag_q && ie_q;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED && !wr_cnt) |=> $stable(cnt)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_int && !reg_wdata[0])) |=> flag_q); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q); // R8

    AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !match_pulse); // R7

endmodule

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       match_pulse;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_cnt, m_per, m_ctrl, m_pre, m_post, m_flag, m_ie;

    always #10 clk = ~clk;

    period_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .match_pulse(match_pulse), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_read(input int a);
        case (a)
            0: return m_cnt;
            1: return m_per;
            2: return m_ctrl;
            default: return m_ie * 2 + m_flag;
        endcase
    endfunction

    // One clock: drive, compare the model on this cycle, advance the model.
    task automatic cyc(input int a, input bit w, input int d);
        int div, tk, mt, sv, clr;
        reg_addr = a[1:0];
        reg_wr = w;
        reg_wdata = d[7:0];
        #1;
        div = ((m_ctrl & 3) == 0) ? 1 : ((m_ctrl & 3) == 1) ? 4 : 16;
        clr = (w && (a == 0 || a == 2)) ? 1 : 0;
        tk = (((m_ctrl >> 2) & 1) == 1 && clr == 0 && m_pre == div - 1) ? 1 : 0;
        mt = (tk == 1 && m_cnt == m_per) ? 1 : 0;
        sv = (mt == 1 && m_post == ((m_ctrl >> 3) & 15)) ? 1 : 0;
        chk({cur_req, " read (R4)"}, int'(reg_rdata), m_read(a));
        chk("R5 match_pulse", int'(match_pulse), mt);
        chk("R9 irq", int'(irq), m_flag & m_ie);
        @(posedge clk);
        if (clr == 1) begin
            m_pre = 0;
            m_post = 0;
        end else begin
            if (((m_ctrl >> 2) & 1) == 1) m_pre = (tk == 1) ? 0 : m_pre + 1;
            if (mt == 1) m_post = (sv == 1) ? 0 : m_post + 1;
        end
        if (w && a == 0) m_cnt = d & 255;
        else if (tk == 1) m_cnt = (mt == 1) ? 0 : (m_cnt + 1) % 256;
        if (w && a == 1) m_per = d & 255;
        if (w && a == 2) m_ctrl = d & 127;
        if (sv == 1) m_flag = 1;
        else if (w && a == 3 && (d & 1) == 0) m_flag = 0;
        if (w && a == 3) m_ie = (d >> 1) & 1;
        @(negedge clk);
    endtask

    task automatic rd(input int a);
        cyc(a, 1'b0, 0);
    endtask

    task automatic wr(input int a, input int d);
        cyc(a, 1'b1, d);
    endtask

    task automatic idle(input int n, input int a);
        for (int i = 0; i < n; i++) rd(a);
    endtask

    initial begin
        m_cnt = 0; m_per = 255; m_ctrl = 0; m_pre = 0; m_post = 0; m_flag = 0; m_ie = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        #1;
        chk("R1 counter reset", int'(reg_rdata), 0);
        for (int a = 0; a < 4; a++) rd(a);

        cur_req = "R4";
        wr(2, 8'h80);
        reg_addr = 2'd2; #1;
        chk("R4 control bit 7 reads 0", int'(reg_rdata), 0);
        wr(1, 8'h03);
        reg_addr = 2'd1; #1;
        chk("R4 period readback", int'(reg_rdata), 3);
        wr(3, 8'h02);
        idle(3, 1);

        cur_req = "R6";
        wr(2, 8'h0C);
        idle(20, 0);
        reg_addr = 2'd3; #1;
        chk("R6 flag after two matches", int'(reg_rdata), 3);
        chk("R9 irq with flag and enable", int'(irq), 1);

        cur_req = "R8";
        wr(2, 8'h08);
        wr(3, 8'h02);
        wr(3, 8'h03);
        reg_addr = 2'd3; #1;
        chk("R8 write 1 leaves flag clear", int'(reg_rdata), 2);
        wr(1, 8'h00);
        wr(2, 8'h04);
        for (int i = 0; i < 12; i++) wr(3, 8'h02);
        reg_addr = 2'd3; #1;
        chk("R8 set wins over clear", int'(reg_rdata), 3);

        cur_req = "R9";
        wr(3, 8'h00);
        idle(5, 3);
        chk("R9 irq masked", int'(irq), 0);

        cur_req = "R3";
        wr(1, 8'h02);
        wr(2, 8'h05);
        idle(40, 0);
        wr(2, 8'h06);
        idle(100, 0);
        wr(2, 8'h07);
        idle(100, 0);

        cur_req = "R7";
        wr(0, 8'h10);
        idle(7, 0);
        wr(0, 8'h00);
        idle(20, 0);
        wr(2, 8'h07);
        idle(40, 0);

        cur_req = "R6";
        wr(3, 8'h02);
        wr(1, 8'h03);
        wr(2, 8'h7F);
        idle(1000, 3);
        reg_addr = 2'd3; #1;
        chk("R6 no flag before 16th match", int'(reg_rdata), 2);
        idle(40, 3);
        reg_addr = 2'd3; #1;
        chk("R6 flag at 16th match", int'(reg_rdata), 3);

        cur_req = "R2";
        wr(2, 8'h78);
        idle(30, 0);
        wr(0, 8'h42);
        idle(10, 0);
        reg_addr = 2'd0; #1;
        chk("R2 stopped counter holds", int'(reg_rdata), 8'h42);

        cur_req = "R5";
        wr(3, 8'h02);
        wr(1, 8'h05);
        wr(0, 8'h20);
        wr(2, 8'h04);
        idle(300, 0);
        wr(1, 8'hFF);
        wr(0, 8'h00);
        idle(300, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule